// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies a square N×N matrix A by an N×P matrix B on a grid of N by P multiply-accumulate elements. Every element owns one entry of the product and keeps its running sum locally. Each clock, one column of A is presented on the left edge and the matching row of B on the top edge. Internal skew registers line the operands up so that matching terms meet in the right element. N consecutive clocks form one block. A free-running counter marks the last term of every block.

On that last term each element moves its finished sum into a private holding register and starts the next block from zero. A command broadcast along the rows then makes the whole grid load its held results into a downward chain. That chain empties through the bottom edge, one row of C per clock with the highest row first. De-skew registers on the bottom edge put the P entries of each row side by side. Blocks can follow each other with no idle clocks, and the output streams without gaps.

Top module: `sa_matmul`

## Requirements
- R1: While rst_n is low, and after reset until the first result row is due (R4), c_row_o is all zeros.
- R2: Counting sampling edges after reset release from k = 0, edge k takes inner index k mod N of block floor(k/N). Lane i of a_col_i (bits [i*DATA_W +: DATA_W]) carries A[i][k]. Lane j of b_row_i (bits [j*DATA_W +: DATA_W]) carries B[k][j].
- R3: Each output entry equals the exact two's-complement sum over k of A[i][k]·B[k][j], with operands treated as signed.
- R4: Row N−1−r (r = 0..N−1) of block b is present on c_row_o right after edge (b+2)·N + P − 2 + r, and it holds until the next edge.
- R5: The rows of one block leave in descending row order, one row per clock, with no gap between them.
- R6: All P entries of a row appear in the same clock. Entry j is at bits [j*ACC_W +: ACC_W].
- R7: The accumulator is 2·DATA_W + clog2(N) bits wide. Extreme operands (all −2^(DATA_W−1), or a mix with the largest positive value) give exact results with no wrap.
- R8: Blocks may follow back to back. Each result depends only on its own block, because every element clears its running sum when it stores a result.
- R9: Operands move one element per clock, unchanged: A values move rightward along a row, and B values move downward along a column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Deassertion must be synchronous to clk. |
| a_col_i | input | DIM_N*DATA_W | One column of A, one signed lane per row |
| b_row_i | input | COLS_P*DATA_W | One row of B, one signed lane per column |
| c_row_o | output | COLS_P*(2*DATA_W+clog2(DIM_N)) | One row of C, one signed lane per column |

## Verification
The timing rule of R4 fixes every output of the block. Row N−1−r of block b is due right after edge (b+2)·N + P − 2 + r. That count includes the skew registers, one register per element hop, the inject cycle that runs one block behind the store, and the bottom de-skew stages. The bench counts sampling edges from reset release and drives the operand vector for edge k just before that edge. It samples c_row_o at the falling edge after every rising edge. For each sample it works out which row of which block is due, or that zeros are due, and compares every lane against a sum of products computed by the bench.

// File: rtl/sa_matmul_pkg.sv
package sa_matmul_pkg;

  // Downward-chain command, broadcast along each row.
  typedef enum logic {
    FLOW_PASS   = 1'b0,
    FLOW_INJECT = 1'b1
  } flow_cmd_e;

  // Arithmetic command, skewed together with the A operand.
  typedef enum logic {
    ARITH_ACC   = 1'b0,
    ARITH_STORE = 1'b1
  } arith_cmd_e;

endpackage

// File: rtl/sa_matmul_seq.sv
module sa_matmul_seq
  import sa_matmul_pkg::*;
#(
  parameter int DIM_N = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  output flow_cmd_e  flow_o,
  output arith_cmd_e arith_o
);

  localparam int CNT_W = (DIM_N > 1) ? $clog2(DIM_N) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIM_N - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             last_term;

  always_comb begin
    last_term = (cnt_q == CNT_LAST);
    cnt_d     = last_term ? '0 : cnt_q + 1'b1;
    flow_o    = last_term ? FLOW_INJECT : FLOW_PASS;
    arith_o   = last_term ? ARITH_STORE : ARITH_ACC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R2: block framing counter stays in range and wraps after the last term
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);
  assert_cnt_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_LAST) |=> (cnt_q == '0));

endmodule

// File: rtl/sa_matmul_skew.sv
module sa_matmul_skew #(
  parameter int               WIDTH   = 8,
  parameter int               DEPTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_regs
      logic [WIDTH-1:0] stage_q [DEPTH];
      logic [WIDTH-1:0] stage_d [DEPTH];

      always_comb begin
        stage_d[0] = din;
        for (int k = 1; k < DEPTH; k++) begin
          stage_d[k] = stage_q[k-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < DEPTH; k++) begin
            stage_q[k] <= RST_VAL;
          end
        end else begin
          for (int k = 0; k < DEPTH; k++) begin
            stage_q[k] <= stage_d[k];
          end
        end
      end

      assign dout = stage_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/sa_matmul_pe.sv
module sa_matmul_pe
  import sa_matmul_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [DATA_W-1:0] a_i,
  input  arith_cmd_e               arith_i,
  input  flow_cmd_e                flow_i,
  input  logic signed [DATA_W-1:0] b_i,
  input  logic signed [ACC_W-1:0]  dn_i,
  output logic signed [DATA_W-1:0] a_o,
  output arith_cmd_e               arith_o,
  output flow_cmd_e                flow_o,
  output logic signed [DATA_W-1:0] b_o,
  output logic signed [ACC_W-1:0]  dn_o
);

  localparam int PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  sum;

  logic signed [DATA_W-1:0] a_q, a_d, b_q, b_d;
  arith_cmd_e               arith_q, arith_d;
  flow_cmd_e                flow_q, flow_d;
  logic signed [ACC_W-1:0]  acc_q, acc_d;
  logic signed [ACC_W-1:0]  res_q, res_d;
  logic signed [ACC_W-1:0]  dn_q, dn_d;

  always_comb begin
    prod    = a_i * b_i;
    sum     = acc_q + ACC_W'(prod);
    a_d     = a_i;
    b_d     = b_i;
    arith_d = arith_i;
    flow_d  = flow_i;
    if (arith_i == ARITH_STORE) begin
      acc_d = '0;
      res_d = sum;
    end else begin
      acc_d = sum;
      res_d = res_q;
    end
    dn_d = (flow_i == FLOW_INJECT) ? res_q : dn_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      arith_q <= ARITH_STORE;
      flow_q  <= FLOW_INJECT;
      acc_q   <= '0;
      res_q   <= '0;
      dn_q    <= '0;
    end else begin
      a_q     <= a_d;
      b_q     <= b_d;
      arith_q <= arith_d;
      flow_q  <= flow_d;
      acc_q   <= acc_d;
      res_q   <= res_d;
      dn_q    <= dn_d;
    end
  end

  assign a_o     = a_q;
  assign b_o     = b_q;
  assign arith_o = arith_q;
  assign flow_o  = flow_q;
  assign dn_o    = dn_q;

  // R8: a store leaves the running sum at zero for the next block
  assert_store_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (arith_i == ARITH_STORE) |=> (acc_q == '0));
  // R5: on a pass the chain value moves down one element per clock
  assert_chain_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_i == FLOW_PASS) |=> (dn_o == $past(dn_i)));
  // R9: operands advance one hop per clock, unchanged
  assert_operand_hop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (a_o == $past(a_i)) && (b_o == $past(b_i)));

endmodule

// File: rtl/sa_matmul.sv
module sa_matmul
  import sa_matmul_pkg::*;
#(
  parameter int DIM_N  = 4,
  parameter int COLS_P = 3,
  parameter int DATA_W = 8
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic [DIM_N*DATA_W-1:0]                          a_col_i,
  input  logic [COLS_P*DATA_W-1:0]                         b_row_i,
  output logic [COLS_P*(2*DATA_W+$clog2(DIM_N))-1:0]       c_row_o
);

  localparam int ACC_W  = 2 * DATA_W + $clog2(DIM_N);
  localparam int LANE_W = DATA_W + 1;
  localparam logic [LANE_W-1:0] LEFT_RST = {1'b1, {DATA_W{1'b0}}};

  flow_cmd_e  cmd_flow;
  arith_cmd_e cmd_arith;

  logic signed [DATA_W-1:0] a_h     [DIM_N][COLS_P+1];
  arith_cmd_e               arith_h [DIM_N][COLS_P+1];
  flow_cmd_e                flow_h  [DIM_N][COLS_P+1];
  logic signed [DATA_W-1:0] b_v     [DIM_N+1][COLS_P];
  logic signed [ACC_W-1:0]  dn_v    [DIM_N+1][COLS_P];

  sa_matmul_seq #(.DIM_N(DIM_N)) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .flow_o  (cmd_flow),
    .arith_o (cmd_arith)
  );

  genvar gi, gj;
  generate
    // Left edge: row i delayed by i clocks, command travels with the operand.
    for (gi = 0; gi < DIM_N; gi++) begin : g_left
      logic [LANE_W-1:0] lane_in, lane_out;
      assign lane_in = {cmd_arith, a_col_i[gi*DATA_W +: DATA_W]};
      sa_matmul_skew #(.WIDTH(LANE_W), .DEPTH(gi), .RST_VAL(LEFT_RST)) skew_i (
        .clk(clk), .rst_n(rst_n), .din(lane_in), .dout(lane_out)
      );
      assign a_h[gi][0]     = lane_out[DATA_W-1:0];
      assign arith_h[gi][0] = arith_cmd_e'(lane_out[DATA_W]);
      assign flow_h[gi][0]  = cmd_flow;
    end

    // Top edge: column j delayed by j clocks; chain starts empty.
    for (gj = 0; gj < COLS_P; gj++) begin : g_top
      logic [DATA_W-1:0] lane_out;
      sa_matmul_skew #(.WIDTH(DATA_W), .DEPTH(gj), .RST_VAL('0)) skew_i (
        .clk(clk), .rst_n(rst_n), .din(b_row_i[gj*DATA_W +: DATA_W]), .dout(lane_out)
      );
      assign b_v[0][gj]  = lane_out;
      assign dn_v[0][gj] = '0;
    end

    for (gi = 0; gi < DIM_N; gi++) begin : g_row
      for (gj = 0; gj < COLS_P; gj++) begin : g_col
        sa_matmul_pe #(.DATA_W(DATA_W), .ACC_W(ACC_W)) pe_i (
          .clk     (clk),
          .rst_n   (rst_n),
          .a_i     (a_h[gi][gj]),
          .arith_i (arith_h[gi][gj]),
          .flow_i  (flow_h[gi][gj]),
          .b_i     (b_v[gi][gj]),
          .dn_i    (dn_v[gi][gj]),
          .a_o     (a_h[gi][gj+1]),
          .arith_o (arith_h[gi][gj+1]),
          .flow_o  (flow_h[gi][gj+1]),
          .b_o     (b_v[gi+1][gj]),
          .dn_o    (dn_v[gi+1][gj])
        );
      end
    end

    // Bottom edge: column j delayed by COLS_P-1-j clocks to align a row.
    for (gj = 0; gj < COLS_P; gj++) begin : g_bot
      logic [ACC_W-1:0] lane_out;
      sa_matmul_skew #(.WIDTH(ACC_W), .DEPTH(COLS_P-1-gj), .RST_VAL('0)) skew_i (
        .clk(clk), .rst_n(rst_n), .din(dn_v[DIM_N][gj]), .dout(lane_out)
      );
      assign c_row_o[gj*ACC_W +: ACC_W] = lane_out;
    end
  endgenerate

  // Operands and commands leaving the right and bottom edges are not used.
  logic unused_edge;
  always_comb begin
    unused_edge = 1'b0;
    for (int i = 0; i < DIM_N; i++) begin
      unused_edge = unused_edge ^ (^a_h[i][COLS_P]) ^ arith_h[i][COLS_P] ^ flow_h[i][COLS_P];
    end
    for (int j = 0; j < COLS_P; j++) begin
      unused_edge = unused_edge ^ (^b_v[DIM_N][j]);
    end
  end

endmodule

// File: tb/sa_matmul_tb_top.sv
module sa_matmul_tb_top;

  localparam int N          = 4;
  localparam int P          = 3;
  localparam int W          = 8;
  localparam int ACC_W      = 2 * W + $clog2(N);
  localparam int NB         = 12;
  localparam int CLK_PERIOD = 10;
  localparam int LAST_EDGE  = (NB + 3) * N + P + 2;

  logic                 clk;
  logic                 rst_n;
  logic [N*W-1:0]       a_col_i;
  logic [P*W-1:0]       b_row_i;
  logic [P*ACC_W-1:0]   c_row_o;

  int a_m [NB][N][N];
  int b_m [NB][N][P];
  int checks;
  int fails;
  bit done;

  sa_matmul #(.DIM_N(N), .COLS_P(P), .DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_col_i(a_col_i), .b_row_i(b_row_i), .c_row_o(c_row_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic longint exp_c(int blk, int row, int col);
    longint s = 0;
    for (int k = 0; k < N; k++) s += longint'(a_m[blk][row][k]) * longint'(b_m[blk][k][col]);
    return s;
  endfunction

  function automatic int rnd8();
    return int'($urandom % 256) - 128;
  endfunction

  task automatic drive(int e);
    int blk = e / N;
    int k   = e % N;
    for (int i = 0; i < N; i++)
      a_col_i[i*W +: W] = (blk < NB) ? W'(a_m[blk][i][k]) : '0;
    for (int j = 0; j < P; j++)
      b_row_i[j*W +: W] = (blk < NB) ? W'(b_m[blk][k][j]) : '0;
  endtask

  task automatic check_lane(int j, longint expv, string tag);
    logic signed [ACC_W-1:0] got;
    longint gotl;
    got  = c_row_o[j*ACC_W +: ACC_W];
    gotl = longint'(got);
    checks++;
    if (gotl !== expv) begin
      fails++;
      $display("FAIL %s lane %0d: actual %0d expected %0d", tag, j, gotl, expv);
    end
  endtask

  // Sample after edge e; work out which row (or zeros) is due per R4.
  task automatic check_edge(int e);
    int v = e - (P - 2);
    if (v < 2 * N) begin
      for (int j = 0; j < P; j++) check_lane(j, 0, "R1 zeros before first row");
    end else begin
      int blk = v / N - 2;
      int row = N - 1 - (v % N);
      if (blk >= NB) begin
        for (int j = 0; j < P; j++) check_lane(j, 0, "R8 idle blocks give zero");
      end else begin
        string tag;
        if (blk == 1 || blk == 2) tag = "R7 R3 extreme operands";
        else tag = "R2 R3 R4 R5 R6 R8 R9 row result";
        for (int j = 0; j < P; j++) check_lane(j, exp_c(blk, row, j), tag);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < N; i++)
        for (int k = 0; k < N; k++) begin
          case (b)
            0:       a_m[b][i][k] = i + 2 * k - 3;
            1:       a_m[b][i][k] = -128;
            2:       a_m[b][i][k] = 127;
            3:       a_m[b][i][k] = (i == k) ? 1 : 0;
            default: a_m[b][i][k] = rnd8();
          endcase
        end
      for (int k = 0; k < N; k++)
        for (int j = 0; j < P; j++) begin
          case (b)
            0:       b_m[b][k][j] = k * j - 2;
            1:       b_m[b][k][j] = -128;
            2:       b_m[b][k][j] = -128;
            default: b_m[b][k][j] = rnd8();
          endcase
        end
    end
  end

  initial begin
    checks  = 0;
    fails   = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    a_col_i = '0;
    b_row_i = '0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      for (int j = 0; j < P; j++) check_lane(j, 0, "R1 reset output");
    end
    rst_n = 1'b1;
    drive(0);
    for (int e = 0; e < LAST_EDGE; e++) begin
      @(posedge clk);
      @(negedge clk);
      check_edge(e);
      drive(e + 1);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule